// File: doc/BRIEF.md
# Two's-Complement Adder/Subtractor with Carry and Overflow Flags

This block is a purely combinational n-bit adder/subtractor for two's-complement and unsigned operands. One control input picks the operation. For addition the second operand goes straight into a ripple chain of full adders. For subtraction every bit of the second operand is inverted with an XOR gate, and the same control bit enters the chain as its carry-in. The result is the first operand plus the two's complement of the second.

Two status flags come out beside the result. The carry flag is the carry out of the most significant stage, which is the overflow indicator for unsigned operands. During subtraction a carry of 1 means that no borrow occurred. The overflow flag is the signed overflow indicator. It is taken as the XOR of the carries into and out of the sign stage. Inside the block it is cross-checked against a second form that uses only the sign bits of the operands and of the result. The width is a parameter with a default of 8.

Top module: `addsub_flags`

## Requirements
- R1: With sub_i = 0, sum_o equals (a_i + b_i) modulo 2^WIDTH.
- R2: With sub_i = 1, sum_o equals (a_i - b_i) modulo 2^WIDTH.
- R3: With sub_i = 0, carry_o is bit WIDTH of the unsigned sum a_i + b_i. It is 1 exactly when the unsigned result does not fit in WIDTH bits.
- R4: With sub_i = 1, carry_o is 1 exactly when a_i >= b_i as unsigned numbers, meaning no borrow. For b_i = 0 it is always 1.
- R5: ovf_o is 1 exactly when the true signed result lies outside -2^(WIDTH-1) .. 2^(WIDTH-1)-1, with both operands read as two's complement.
- R6: ovf_o always equals the sign form. That form is 1 when a_i[MSB] and the adder's second input bit (b_i[MSB] XOR sub_i) are both 1 and sum_o[MSB] is 0. It is also 1 when both of those bits are 0 and sum_o[MSB] is 1. Otherwise it is 0.
- R7: The outputs depend only on the present inputs and hold no state. An input change shows at the outputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand (minuend for subtraction) |
| b_i | input | WIDTH | Second operand (subtrahend for subtraction) |
| sub_i | input | 1 | Operation select: 0 add, 1 subtract |
| sum_o | output | WIDTH | Result modulo 2^WIDTH |
| carry_o | output | 1 | Carry out of the top stage (unsigned overflow, or no-borrow during subtraction) |
| ovf_o | output | 1 | Signed overflow |

## Verification
A 4-bit copy is driven through every pair of operands under both operations. This covers every carry and borrow pattern, and every way to overflow toward the positive and the negative limit. It also separates the carry flag from the overflow flag, since vectors exist that raise each flag alone. The default-width copy receives directed corner operands and random vectors: the most negative value, all ones, zero, and subtracting a value from itself. These show whether inversion and carry injection reach every bit position. A mid-cycle input change with no clock edge shows that the outputs follow the inputs without holding any state.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  // Signed overflow from sign bits alone: like-signed inputs, opposite-signed result.
  function automatic logic sign_ovf(input logic a_msb, input logic b_msb, input logic s_msb);
    return (a_msb & b_msb & ~s_msb) | (~a_msb & ~b_msb & s_msb);
  endfunction
endpackage

// File: rtl/fa_cell.sv
module fa_cell (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic gen, prop;
  assign gen = x_i & y_i;
  assign prop = x_i | y_i;
  assign s_o = x_i ^ y_i ^ c_i;
  assign c_o = gen | (prop & c_i);
endmodule

// File: rtl/ripple_chain.sv
module ripple_chain #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] s_o,
  output logic [WIDTH:0]   c_o
);
  assign c_o[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    fa_cell u_fa (
      .x_i(x_i[i]),
      .y_i(y_i[i]),
      .c_i(c_o[i]),
      .s_o(s_o[i]),
      .c_o(c_o[i+1])
    );
  end
endmodule

// File: rtl/operand_cond.sv
module operand_cond #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] b_o
);
  // Bitwise XOR with the control yields one's complement when subtracting.
  for (genvar i = 0; i < WIDTH; i++) begin : g_inv
    assign b_o[i] = b_i[i] ^ sub_i;
  end
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  import addsub_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   carries;

  operand_cond #(.WIDTH(WIDTH)) u_cond (
    .b_i  (b_i),
    .sub_i(sub_i),
    .b_o  (b_eff)
  );

  ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .x_i  (a_i),
    .y_i  (b_eff),
    .cin_i(sub_i),
    .s_o  (sum_o),
    .c_o  (carries)
  );

  assign carry_o = carries[WIDTH];
  assign ovf_o   = carries[WIDTH] ^ carries[MSB];

  logic [WIDTH:0] ref_add;
  logic [WIDTH:0] ref_sub;
  assign ref_add = {1'b0, a_i} + {1'b0, b_i};
  assign ref_sub = {1'b0, a_i} - {1'b0, b_i};

  always_comb begin
    assert_add_sum_R1: assert (sub_i || sum_o == ref_add[MSB:0])
      else $error("adder sum mismatch");
    assert_sub_diff_R2: assert (!sub_i || sum_o == ref_sub[MSB:0])
      else $error("subtractor difference mismatch");
    assert_add_carry_R3: assert (sub_i || carry_o == ref_add[WIDTH])
      else $error("add carry mismatch");
    assert_no_borrow_R4: assert (!sub_i || carry_o == (a_i >= b_i))
      else $error("borrow flag mismatch");
    assert_ovf_forms_agree_R6: assert (ovf_o == sign_ovf(a_i[MSB], b_i[MSB] ^ sub_i, sum_o[MSB]))
      else $error("overflow forms disagree");
  end
endmodule

// File: tb/sim_addsub_flags.sv
module sim_addsub_flags;
  localparam int WW = 8;
  localparam int WN = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [WW-1:0] a_w, b_w, s_w;
  logic          sub_w, c_w, v_w;
  logic [WN-1:0] a_n, b_n, s_n;
  logic          sub_n, c_n, v_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  addsub_flags #(.WIDTH(WW)) u0 (
    .a_i(a_w), .b_i(b_w), .sub_i(sub_w),
    .sum_o(s_w), .carry_o(c_w), .ovf_o(v_w)
  );

  addsub_flags #(.WIDTH(WN)) u0_narrow (
    .a_i(a_n), .b_i(b_n), .sub_i(sub_n),
    .sum_o(s_n), .carry_o(c_n), .ovf_o(v_n)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model from the requirements; n is the width under test.
  task automatic check_vec(input int n, input longint a, input longint b, input bit sub,
                           input longint s, input bit c, input bit v);
    longint mask = (64'sd1 <<< n) - 1;
    longint half = 64'sd1 <<< (n - 1);
    longint sa   = (a >= half) ? a - (mask + 1) : a;
    longint sb   = (b >= half) ? b - (mask + 1) : b;
    longint sr   = sub ? sa - sb : sa + sb;
    longint es   = (sub ? a - b : a + b) & mask;
    bit     ec   = sub ? (a >= b) : (((a + b) >>> n) & 1) == 1;
    bit     ev   = (sr < -half) || (sr > half - 1);
    bit     am   = ((a >>> (n - 1)) & 1) == 1;
    bit     bm   = (((b >>> (n - 1)) & 1) == 1) ^ sub;
    bit     sm   = ((s >>> (n - 1)) & 1) == 1;
    bit     fv   = (am & bm & ~sm) | (~am & ~bm & sm);
    if (sub) begin
      chk("R2 difference", s, es);
      chk("R4 no-borrow", c, ec);
    end else begin
      chk("R1 sum", s, es);
      chk("R3 carry", c, ec);
    end
    chk("R5 signed overflow", v, ev);
    chk("R6 sign form", v, fv);
  endtask

  task automatic apply_w(input logic [WW-1:0] a, input logic [WW-1:0] b, input bit sub);
    @(posedge clk);
    a_w = a; b_w = b; sub_w = sub;
    @(negedge clk);
    check_vec(WW, longint'(a), longint'(b), sub, longint'(s_w), c_w, v_w);
  endtask

  task automatic t_idle;
    @(negedge clk);
    chk("R1 idle sum zero", longint'(s_w), 0);
    chk("R3 idle carry zero", longint'(c_w), 0);
    chk("R5 idle overflow zero", longint'(v_w), 0);
  endtask

  task automatic t_directed;
    apply_w(8'd100, 8'd27, 1'b0);
    apply_w(8'd127, 8'd1, 1'b0);     // R5 positive overflow
    apply_w(8'd128, 8'd255, 1'b0);   // R5 negative overflow with carry
    apply_w(8'd255, 8'd1, 1'b0);     // R3 carry without signed overflow
    apply_w(8'd128, 8'd128, 1'b0);
    apply_w(8'd128, 8'd1, 1'b1);     // R5 min minus one
    apply_w(8'd0, 8'd128, 1'b1);     // R5 zero minus min
    apply_w(8'd5, 8'd9, 1'b1);       // R4 borrow
    apply_w(8'd77, 8'd77, 1'b1);     // R4 equal operands
    apply_w(8'd200, 8'd0, 1'b1);     // R4 subtrahend zero
    apply_w(8'd0, 8'd0, 1'b1);
  endtask

  task automatic t_random;
    for (int k = 0; k < 3000; k++)
      apply_w(WW'($urandom), WW'($urandom), 1'($urandom));
  endtask

  task automatic t_exhaustive_narrow;
    for (int sb = 0; sb < 2; sb++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          @(posedge clk);
          a_n = WN'(a); b_n = WN'(b); sub_n = sb[0];
          @(negedge clk);
          check_vec(WN, longint'(a), longint'(b), sb[0], longint'(s_n), c_n, v_n);
        end
  endtask

  // R7: change inputs between edges and observe with no clock edge in between.
  task automatic t_no_state;
    @(negedge clk);
    #2;
    a_w = 8'd250; b_w = 8'd10; sub_w = 1'b0;
    #1;
    chk("R7 mid-cycle sum", longint'(s_w), 4);
    chk("R7 mid-cycle carry", longint'(c_w), 1);
    sub_w = 1'b1;
    #1;
    chk("R7 mid-cycle diff", longint'(s_w), 240);
    chk("R7 mid-cycle no-borrow", longint'(c_w), 1);
  endtask

  initial begin
    a_w = '0; b_w = '0; sub_w = 1'b0;
    a_n = '0; b_n = '0; sub_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    t_idle();
    t_directed();
    t_no_state();
    t_exhaustive_narrow();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule